// File: doc/BRIEF.md
# Circular Stream Buffer Address Controller

This block tracks one ring buffer that lives in a contiguous window of external memory. Software sets the window with a base register and a limit register while the block is stopped. Once running, the block keeps a fill pointer and a drain pointer inside the window. The fill pointer serves the upstream source and the drain pointer serves the consumer. Each pointer steps by one word per accepted transfer and returns to the base after the limit. Only addresses and an occupancy count are modelled. The memory, any staging FIFOs and the decoding logic sit outside the block.

A separate occupancy counter tells full from empty, so equal pointers are never ambiguous. Full depends only on that count: whatever sits in staging FIFOs outside the block is ignored. The two ends of the buffer are handled as protocol events. At full, the request line toward the source drops and further incoming words are thrown away. At empty, the consumer is refused until data arrives. Entering either state latches a sticky error flag, and each flag can drive a shared interrupt through its own enable bit.

Top module: `cbuf_ctrl`

## Requirements
- R1: After synchronous reset, both addresses equal the reset base (default 0), the level is 0, empty is 1, full is 0, and both error flags and irq are 0.
- R2: While run is 0, a cfg_we pulse writes cfg_wdata into the base register (cfg_sel=0) or the limit register (cfg_sel=1). The same pulse sets both addresses to the resulting base and the level to 0. While run is 1, cfg_we has no effect on the bounds.
- R3: While run is 1 and full is 0, wr_stb is accepted. wr_addr advances by one on the next edge and the level increases by one.
- R4: While run is 1 and empty is 0, rd_req is granted (rd_grant=1). rd_addr advances by one on the next edge and the level decreases by one.
- R5: A pointer that advances from the limit address moves to the base address.
- R6: full is 1 when the level equals limit-base+1. data_req is 1 only while run is 1 and full is 0. wr_stb while full changes neither wr_addr nor the level.
- R7: rd_req while empty is not granted and changes neither rd_addr nor the level.
- R8: err_ovf sets on the edge where the level reaches capacity. err_unf sets on the edge where a read brings the level to 0. Both flags stay set until cleared.
- R9: err_clr bit 0 clears err_ovf and bit 1 clears err_unf. A flag being set in the same cycle wins over its clear.
- R10: irq equals (err_ovf AND irq_en[0]) OR (err_unf AND irq_en[1]), combinationally.
- R11: When a write is accepted and a read is granted in the same cycle, both addresses advance and the level stays the same.
- R12: While run is 0, no write is accepted and no read is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Operating enable; bounds may be changed only while low |
| cfg_we | input | 1 | Bounds register write strobe |
| cfg_sel | input | 1 | 0 selects base, 1 selects limit |
| cfg_wdata | input | AW | Bounds write value |
| wr_stb | input | 1 | Upstream word arrival |
| rd_req | input | 1 | Consumer read request |
| err_clr | input | 2 | Flag clear bits (0: overflow, 1: underflow) |
| irq_en | input | 2 | Interrupt enables (0: overflow, 1: underflow) |
| wr_accept | output | 1 | Incoming word is stored this cycle |
| rd_grant | output | 1 | Read is served this cycle |
| data_req | output | 1 | Request toward the upstream source |
| wr_addr | output | AW | Fill (back) pointer |
| rd_addr | output | AW | Drain (front) pointer |
| level | output | AW+1 | Occupancy in words |
| full | output | 1 | Window fully occupied |
| empty | output | 1 | Window holds no data |
| err_ovf | output | 1 | Sticky overflow flag |
| err_unf | output | 1 | Sticky underflow flag |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with the default 8-bit address and then programs small windows. A four-word window at base 10 lets a few writes reach full, exercise the wrap at the limit and drain back to empty. The short run keeps the dropped-write, refused-read and simultaneous read-and-write cases close together. A one-word window at address 200 covers the case where base equals limit, so a single write fills the buffer and each pointer wraps onto itself.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

    typedef enum logic {
        BND_BASE  = 1'b0,
        BND_LIMIT = 1'b1
    } bnd_sel_e;

    localparam int NUM_ERR = 2;
    localparam int ERR_OVF = 0;
    localparam int ERR_UNF = 1;

    localparam int NUM_PTR = 2;
    localparam int PTR_WR  = 0;
    localparam int PTR_RD  = 1;

    typedef struct packed {
        logic unf;
        logic ovf;
    } err_flags_t;

endpackage

// File: rtl/cbuf_bounds.sv
module cbuf_bounds
    import cbuf_pkg::*;
#(
    parameter int             AW        = 8,
    parameter logic [AW-1:0]  RST_BASE  = '0,
    parameter logic [AW-1:0]  RST_LIMIT = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          cfg_we,
    input  bnd_sel_e      cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] base,
    output logic [AW-1:0] limit,
    output logic          reload,
    output logic [AW-1:0] reload_base,
    output logic [AW:0]   cap
);
    logic [AW-1:0] base_q, limit_q;

    assign reload      = cfg_we & ~run;
    assign reload_base = (cfg_sel == BND_BASE) ? cfg_wdata : base_q;
    assign base        = base_q;
    assign limit       = limit_q;
    assign cap         = {1'b0, limit_q} - {1'b0, base_q} + {{AW{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= RST_BASE;
            limit_q <= RST_LIMIT;
        end else if (reload) begin
            if (cfg_sel == BND_BASE) base_q  <= cfg_wdata;
            else                     limit_q <= cfg_wdata;
        end
    end

    // R2: bounds hold while running
    p_bounds_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        $past(run) && !$past(rst) |-> base_q == $past(base_q) && limit_q == $past(limit_q));

endmodule

// File: rtl/cbuf_ptr.sv
module cbuf_ptr #(
    parameter int            AW      = 8,
    parameter logic [AW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] ptr_q, ptr_step;

    assign ptr_step = (ptr_q == hi) ? lo : ptr_q + {{(AW-1){1'b0}}, 1'b1};
    assign ptr      = ptr_q;

    always_ff @(posedge clk) begin
        if (rst)       ptr_q <= RST_VAL;
        else if (load) ptr_q <= load_val;
        else if (adv)  ptr_q <= ptr_step;
    end

    // R5: stepping off the limit lands on the base
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        adv && !load && ptr_q == hi |=> ptr_q == $past(lo));

    // R3 / R4: an idle pointer stays put
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !adv && !load |=> $stable(ptr_q));

endmodule

// File: rtl/cbuf_occ.sv
module cbuf_occ #(
    parameter int AW = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        inc,
    input  logic        dec,
    input  logic [AW:0] cap,
    output logic [AW:0] level,
    output logic        full,
    output logic        empty
);
    logic [AW:0] level_q;
    localparam logic [AW:0] ONE = {{AW{1'b0}}, 1'b1};

    assign level = level_q;
    assign full  = (level_q == cap);
    assign empty = (level_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clear)     level_q <= '0;
        else if (inc && !dec) level_q <= level_q + ONE;
        else if (dec && !inc) level_q <= level_q - ONE;
    end

    // R6: occupancy never exceeds the window
    p_level_cap_r6: assert property (@(posedge clk) disable iff (rst)
        level_q <= cap);

    // R11: concurrent fill and drain keep the level
    p_level_hold_r11: assert property (@(posedge clk) disable iff (rst)
        inc && dec && !clear |=> level_q == $past(level_q));

endmodule

// File: rtl/cbuf_err.sv
module cbuf_err
    import cbuf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_ERR-1:0] set,
    input  logic [NUM_ERR-1:0] clr,
    input  logic [NUM_ERR-1:0] en,
    output err_flags_t         flags,
    output logic               irq
);
    err_flags_t flags_q;

    assign flags = flags_q;
    assign irq   = |(flags_q & en);

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr) | set;
    end

    // R8 / R9: a flag survives unless its clear bit is present
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        flags_q.ovf && !clr[ERR_OVF] |=> flags_q.ovf);

    // R9: a concurrent set outranks clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        set[ERR_UNF] |=> flags_q.unf);

endmodule

// File: rtl/cbuf_ctrl.sv
module cbuf_ctrl
    import cbuf_pkg::*;
#(
    parameter int            AW        = 8,
    parameter logic [AW-1:0] RST_BASE  = '0,
    parameter logic [AW-1:0] RST_LIMIT = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          wr_stb,
    input  logic          rd_req,
    input  logic [1:0]    err_clr,
    input  logic [1:0]    irq_en,
    output logic          wr_accept,
    output logic          rd_grant,
    output logic          data_req,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   level,
    output logic          full,
    output logic          empty,
    output logic          err_ovf,
    output logic          err_unf,
    output logic          irq
);
    localparam logic [AW:0] ONE = {{AW{1'b0}}, 1'b1};

    logic [AW-1:0] base, limit, reload_base;
    logic          reload;
    logic [AW:0]   cap;
    logic [AW-1:0] ptr_v [NUM_PTR];
    logic [NUM_PTR-1:0] adv_v;
    logic [NUM_ERR-1:0] err_set;
    err_flags_t    flags;

    cbuf_bounds #(.AW(AW), .RST_BASE(RST_BASE), .RST_LIMIT(RST_LIMIT)) u_bounds (
        .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we),
        .cfg_sel(bnd_sel_e'(cfg_sel)), .cfg_wdata(cfg_wdata),
        .base(base), .limit(limit), .reload(reload),
        .reload_base(reload_base), .cap(cap)
    );

    assign wr_accept = run & wr_stb & ~full;
    assign rd_grant  = run & rd_req & ~empty;
    assign data_req  = run & ~full;

    assign adv_v[PTR_WR] = wr_accept;
    assign adv_v[PTR_RD] = rd_grant;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        cbuf_ptr #(.AW(AW), .RST_VAL(RST_BASE)) u_ptr (
            .clk(clk), .rst(rst), .load(reload), .load_val(reload_base),
            .adv(adv_v[g]), .lo(base), .hi(limit), .ptr(ptr_v[g])
        );
    end

    assign wr_addr = ptr_v[PTR_WR];
    assign rd_addr = ptr_v[PTR_RD];

    cbuf_occ #(.AW(AW)) u_occ (
        .clk(clk), .rst(rst), .clear(reload), .inc(wr_accept), .dec(rd_grant),
        .cap(cap), .level(level), .full(full), .empty(empty)
    );

    assign err_set[ERR_OVF] = wr_accept & ~rd_grant & (level == cap - ONE);
    assign err_set[ERR_UNF] = rd_grant & ~wr_accept & (level == ONE);

    cbuf_err u_err (
        .clk(clk), .rst(rst), .set(err_set), .clr(err_clr), .en(irq_en),
        .flags(flags), .irq(irq)
    );

    assign err_ovf = flags.ovf;
    assign err_unf = flags.unf;

    // R6: request withdrawn at full
    p_req_low_full_r6: assert property (@(posedge clk) disable iff (rst)
        full |-> !data_req);

    // R8: entering full latches overflow
    p_ovf_on_full_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> err_ovf);

    // R8: draining to empty latches underflow
    p_unf_on_empty_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(empty) && $past(run) |-> err_unf);

    // R5: running pointers stay inside the window
    p_in_window_r5: assert property (@(posedge clk) disable iff (rst)
        run && base <= limit |-> wr_addr >= base && wr_addr <= limit
                              && rd_addr >= base && rd_addr <= limit);

    // R12: stopped block moves nothing
    p_stopped_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !run && !reload |=> $stable(level));

endmodule

// File: tb/cbuf_ctrl_tb_top.sv
module cbuf_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          wr_stb = 1'b0;
    logic          rd_req = 1'b0;
    logic [1:0]    err_clr = '0;
    logic [1:0]    irq_en = '0;
    logic          wr_accept, rd_grant, data_req, full, empty, err_ovf, err_unf, irq;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [AW:0]   level;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbuf_ctrl #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .wr_stb(wr_stb), .rd_req(rd_req),
        .err_clr(err_clr), .irq_en(irq_en), .wr_accept(wr_accept),
        .rd_grant(rd_grant), .data_req(data_req), .wr_addr(wr_addr),
        .rd_addr(rd_addr), .level(level), .full(full), .empty(empty),
        .err_ovf(err_ovf), .err_unf(err_unf), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r);
        @(negedge clk);
        wr_stb = w;
        rd_req = r;
        @(posedge clk);
        #1;
        wr_stb = 1'b0;
        rd_req = 1'b0;
    endtask

    task automatic cfg(input logic sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = sel;
        cfg_wdata = AW'(val);
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic state(input string tag, input int wa, input int ra, input int lv);
        chk({tag, " wr_addr"}, int'(wr_addr), wa);
        chk({tag, " rd_addr"}, int'(rd_addr), ra);
        chk({tag, " level"}, int'(level), lv);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        state("R1 reset", 0, 0, 0);
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 flags", int'({err_ovf, err_unf, irq}), 0);
        chk("R12 data_req stopped", int'(data_req), 0);
    endtask

    task automatic t_config();
        cfg(1'b0, 10);
        cfg(1'b1, 13);
        state("R2 bounds load", 10, 10, 0);
        cyc(1'b1, 1'b1);
        state("R12 stopped idle", 10, 10, 0);
    endtask

    task automatic t_fill();
        run = 1'b1;
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0);
        state("R3 three writes", 13, 10, 3);
        chk("R6 data_req open", int'(data_req), 1);
        cyc(1'b1, 1'b0);
        state("R5 write wrap", 10, 10, 4);
        chk("R6 full", int'(full), 1);
        chk("R6 data_req low", int'(data_req), 0);
        chk("R8 ovf set", int'(err_ovf), 1);
        chk("R10 irq masked", int'(irq), 0);
        irq_en = 2'b01;
        #1 chk("R10 irq ovf", int'(irq), 1);
        cyc(1'b1, 1'b0);
        state("R6 drop while full", 10, 10, 4);
    endtask

    task automatic t_concurrent();
        cyc(1'b1, 1'b1);
        state("R11 full both", 10, 11, 3);
        cyc(1'b1, 1'b1);
        state("R11 both advance", 11, 12, 3);
    endtask

    task automatic t_drain();
        cyc(1'b0, 1'b1);
        state("R4 read", 11, 13, 2);
        cyc(1'b0, 1'b1);
        state("R5 read wrap", 11, 10, 1);
        chk("R8 unf clear yet", int'(err_unf), 0);
        cyc(1'b0, 1'b1);
        state("R4 to empty", 11, 11, 0);
        chk("R8 unf set", int'(err_unf), 1);
        chk("R7 empty", int'(empty), 1);
        @(negedge clk);
        rd_req = 1'b1;
        #1 chk("R7 no grant", int'(rd_grant), 0);
        @(posedge clk);
        #1 rd_req = 1'b0;
        state("R7 stalled", 11, 11, 0);
    endtask

    task automatic t_clear();
        irq_en = 2'b10;
        #1 chk("R10 irq unf", int'(irq), 1);
        @(negedge clk) err_clr = 2'b01;
        @(posedge clk);
        #1 err_clr = 2'b00;
        chk("R9 ovf cleared", int'(err_ovf), 0);
        chk("R9 unf kept", int'(err_unf), 1);
        irq_en = 2'b01;
        #1 chk("R10 irq off", int'(irq), 0);
        @(negedge clk) err_clr = 2'b10;
        @(posedge clk);
        #1 err_clr = 2'b00;
        chk("R9 unf cleared", int'(err_unf), 0);
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0);
        err_clr = 2'b01;
        cyc(1'b1, 1'b0);
        err_clr = 2'b00;
        chk("R9 set wins", int'(err_ovf), 1);
        state("R6 refilled", 11, 11, 4);
    endtask

    task automatic t_cfg_running();
        cfg(1'b0, 0);
        state("R2 ignored running", 11, 11, 4);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b1);
        state("R2 base kept", 11, 10, 1);
        cyc(1'b0, 1'b1);
        state("R2 drained", 11, 11, 0);
    endtask

    task automatic t_single();
        run = 1'b0;
        cfg(1'b0, 200);
        cfg(1'b1, 200);
        state("R2 single load", 200, 200, 0);
        run = 1'b1;
        cyc(1'b1, 1'b0);
        state("R6 single full", 200, 200, 1);
        chk("R6 single full flag", int'(full), 1);
        cyc(1'b0, 1'b1);
        state("R5 single wrap", 200, 200, 0);
        chk("R4 single empty", int'(empty), 1);
    endtask

    initial begin
        t_reset();
        t_config();
        t_fill();
        t_concurrent();
        t_drain();
        t_clear();
        t_cfg_running();
        t_single();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule